// File: doc/BRIEF.md
# Forward Control Channel Frame Synchronizer

This block sits behind a bit-recovery circuit on the downlink control channel of an analogue cellular receiver. It takes one recovered bit per `bit_vld` strobe and searches for the 11-bit frame sync word. It confirms frame lock with a second match exactly one frame later. It then keeps lock against a programmable run of sync mismatches. Once locked, it splits each frame into busy/idle flags and the bits of two interleaved message words. It forwards only the word selected by `sel_b`, together with the repeat number and bit position of each forwarded bit.

The frame assumed here opens with 10 dotting bits and 11 sync bits, 21 header bits in all. After the header come 40 groups. Each group is one busy/idle bit followed by 10 data bits. The 400 data bits form ten 40-bit words in the order A, B, A, B and so on, which gives five repeats of each word. A frame is therefore 461 bits long.

A rolling majority of the three most recent busy/idle bits drives the `busy` output, with selectable polarity. Single-cycle events mark every change of lock and every change of the majority. A restart command drops lock, goes back to hunting and asks the upstream bit-recovery logic to re-acquire.

Top module: `fwd_ctl_framer`

## Requirements
- R1: After reset, `in_sync`, `word_vld`, `busy`, `busy_evt`, `sync_evt` and `bitsync_restart` are 0. While hunting, the last 11 accepted bits are compared with 11100010010 (the first received bit is the leftmost) on every valid bit. A first match does not raise `in_sync`.
- R2: After a first match, the bit accepted 461 valid bits later is compared again with the sync word. A match sets `in_sync` one cycle after that bit. A mismatch returns the block to hunting with `in_sync` still 0.
- R3: While locked, the sync word is compared only at the last sync position of each frame. A match clears the mismatch count. Lock is dropped at the mismatch that makes the count of consecutive mismatches reach `miss_lim`. A `miss_lim` of 0 behaves as 1.
- R4: While locked, each data bit of the selected word produces `word_vld`=1 one cycle after it is accepted, with `word_bit` equal to the bit. `sel_b`=0 selects word A, which is data words 0, 2, 4, 6 and 8. `sel_b`=1 selects word B, which is words 1, 3, 5, 7 and 9. `word_rep` gives the repeat number (0 to 4) and `word_pos` gives the bit index in the word (0 for the first received bit). Any other accepted bit gives `word_vld`=0.
- R5: `busy` equals the majority of the three most recent busy/idle bits accepted while locked, XORed with `busy_inv`. It is registered and reflects each new busy/idle bit or polarity change one cycle later. The history starts at 000 after reset.
- R6: `sync_evt` pulses for exactly the one cycle in which `in_sync` takes a new value, and at no other time.
- R7: `busy_evt` pulses for one cycle when a new busy/idle bit changes the majority, and is 0 otherwise.
- R8: `restart` forces hunting and clears `in_sync` and the mismatch count. `bitsync_restart` is 1 for exactly the one cycle after `restart`.
- R9: No word bits are forwarded while `in_sync` is 0. This includes the frame between the first sync match and its confirmation.
- R10: A cycle with `bit_vld`=0 advances no frame position and changes neither `in_sync` nor the word outputs. `word_vld` and `sync_evt` are 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Recovered bit strobe |
| bit_in | input | 1 | Recovered bit |
| restart | input | 1 | Restart frame sync command |
| sel_b | input | 1 | 0 forwards word A, 1 forwards word B |
| busy_inv | input | 1 | Inverts the busy output |
| miss_lim | input | 4 | Consecutive sync mismatches that drop lock |
| word_vld | output | 1 | Forwarded word bit valid |
| word_bit | output | 1 | Forwarded word bit |
| word_rep | output | 3 | Repeat number of the forwarded bit |
| word_pos | output | 6 | Bit index in the word |
| busy | output | 1 | Busy/idle majority, polarity applied |
| busy_evt | output | 1 | Majority changed |
| in_sync | output | 1 | Frame lock status |
| sync_evt | output | 1 | Lock status changed |
| bitsync_restart | output | 1 | Request to re-acquire bit sync |

## Verification
Every result is registered once. Word outputs, busy, both events and the lock status therefore all appear in the cycle after the edge that accepts the bit, or the edge that samples `restart` or `busy_inv`. The bench drives inputs on the falling edge and then samples the outputs on the next falling edge, after exactly one rising edge. It then compares them with a frame model it builds itself from each table entry. Lock changes are checked only at the last sync position of each frame, because that is the only bit at which they are due. Idle cycles are inserted into every frame, and the bench checks that they move nothing.

// File: rtl/fwd_ctl_pkg.sv
package fwd_ctl_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } lock_st_e;
endpackage

// File: rtl/fcs_window.sv
module fcs_window #(
  parameter int SYNC_LEN = 11,
  parameter logic [SYNC_LEN-1:0] SYNC_PAT = 11'b11100010010
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_in,
  output logic match
);
  logic [SYNC_LEN-2:0] win;

  assign match = ({win, bit_in} == SYNC_PAT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win <= '0;
    end else if (bit_vld) begin
      win <= {win[SYNC_LEN-3:0], bit_in};
    end
  end
endmodule

// File: rtl/fcs_lock.sv
module fcs_lock
  import fwd_ctl_pkg::*;
#(
  parameter int FRAME_LEN = 461,
  parameter int SYNC_END  = 20,
  parameter int POS_W     = 9,
  parameter int MISS_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              bit_vld,
  input  logic              match,
  input  logic [MISS_W-1:0] miss_lim,
  output logic [POS_W-1:0]  pos,
  output logic              in_sync,
  output logic              sync_evt
);
  lock_st_e          st;
  logic [MISS_W-1:0] miss;
  logic [POS_W-1:0]  pos_nx;
  logic              at_sync;
  logic              miss_full;

  assign pos_nx    = (pos == POS_W'(FRAME_LEN-1)) ? '0 : pos + 1'b1;
  assign at_sync   = (pos == POS_W'(SYNC_END));
  assign miss_full = ({1'b0, miss} + 1'b1) >= {1'b0, miss_lim};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HUNT;
      pos      <= '0;
      miss     <= '0;
      in_sync  <= 1'b0;
      sync_evt <= 1'b0;
    end else begin
      sync_evt <= 1'b0;
      if (restart) begin
        st       <= ST_HUNT;
        pos      <= '0;
        miss     <= '0;
        in_sync  <= 1'b0;
        sync_evt <= in_sync;
      end else if (bit_vld) begin
        case (st)
          ST_HUNT: begin
            if (match) begin
              st  <= ST_CONFIRM;
              pos <= POS_W'(SYNC_END + 1);
            end
          end
          ST_CONFIRM: begin
            pos <= pos_nx;
            if (at_sync) begin
              if (match) begin
                st       <= ST_LOCKED;
                in_sync  <= 1'b1;
                sync_evt <= 1'b1;
                miss     <= '0;
              end else begin
                st <= ST_HUNT;
              end
            end
          end
          ST_LOCKED: begin
            pos <= pos_nx;
            if (at_sync) begin
              if (match) begin
                miss <= '0;
              end else if (miss_full) begin
                st       <= ST_HUNT;
                in_sync  <= 1'b0;
                sync_evt <= 1'b1;
                miss     <= '0;
              end else begin
                miss <= miss + 1'b1;
              end
            end
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

  // R6
  sync_evt_chk: assert property (@(posedge clk) disable iff (rst)
    sync_evt |-> (in_sync != $past(in_sync)));

  // R2
  lock_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sync) |-> ($past(pos) == POS_W'(SYNC_END)) && $past(bit_vld));

  // R8
  restart_drop_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !in_sync);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld && !restart) |=> $stable(pos) && $stable(in_sync));
endmodule

// File: rtl/fcs_demux.sv
module fcs_demux #(
  parameter int SYNC_END  = 20,
  parameter int GRP       = 10,
  parameter int WORD_BITS = 40,
  parameter int REPEATS   = 5,
  parameter int POS_W     = 9,
  parameter int REP_W     = $clog2(REPEATS),
  parameter int JW        = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             in_sync,
  input  logic [POS_W-1:0] pos,
  input  logic             sel_b,
  output logic             busy_stb,
  output logic             word_vld,
  output logic             word_bit,
  output logic [REP_W-1:0] word_rep,
  output logic [JW-1:0]    word_pos
);
  localparam int SLOT_W = $clog2(GRP + 1);
  localparam int WN_W   = REP_W + 1;

  logic [SLOT_W-1:0] slot;
  logic [JW-1:0]     jpos;
  logic [WN_W-1:0]   wn;
  logic              in_body;

  assign in_body  = bit_vld && (pos > POS_W'(SYNC_END));
  assign busy_stb = in_body && (slot == '0) && in_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot     <= '0;
      jpos     <= '0;
      wn       <= '0;
      word_vld <= 1'b0;
      word_bit <= 1'b0;
      word_rep <= '0;
      word_pos <= '0;
    end else begin
      word_vld <= 1'b0;
      if (bit_vld && (pos == POS_W'(SYNC_END))) begin
        slot <= '0;
        jpos <= '0;
        wn   <= '0;
      end else if (in_body) begin
        slot <= (slot == SLOT_W'(GRP)) ? '0 : slot + 1'b1;
        if (slot != '0) begin
          if (in_sync && (wn[0] == sel_b)) begin
            word_vld <= 1'b1;
            word_bit <= bit_in;
            word_rep <= wn[WN_W-1:1];
            word_pos <= jpos;
          end
          if (jpos == JW'(WORD_BITS-1)) begin
            jpos <= '0;
            wn   <= wn + 1'b1;
          end else begin
            jpos <= jpos + 1'b1;
          end
        end
      end
    end
  end

  // R4
  word_range_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (word_pos < JW'(WORD_BITS)) && (word_rep < REP_W'(REPEATS)));

  // R9
  word_locked_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(in_sync) && $past(bit_vld));
endmodule

// File: rtl/fcs_busy_vote.sv
module fcs_busy_vote (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic bit_in,
  input  logic inv,
  output logic busy,
  output logic busy_evt
);
  logic [2:0] hist;
  logic [2:0] hist_nx;
  logic       maj_cur;
  logic       maj_nx;

  assign hist_nx = stb ? {hist[1:0], bit_in} : hist;
  assign maj_cur = (hist[0] & hist[1]) | (hist[0] & hist[2]) | (hist[1] & hist[2]);
  assign maj_nx  = (hist_nx[0] & hist_nx[1]) | (hist_nx[0] & hist_nx[2]) |
                   (hist_nx[1] & hist_nx[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      busy     <= 1'b0;
      busy_evt <= 1'b0;
    end else begin
      hist     <= hist_nx;
      busy     <= maj_nx ^ inv;
      busy_evt <= maj_nx ^ maj_cur;
    end
  end

  // R7
  busy_evt_chk: assert property (@(posedge clk) disable iff (rst)
    busy_evt |-> $past(stb));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb && $past(!stb) && $stable(inv)) |=> $stable(busy));
endmodule

// File: rtl/fwd_ctl_framer.sv
module fwd_ctl_framer #(
  parameter int SYNC_LEN  = 11,
  parameter logic [SYNC_LEN-1:0] SYNC_PAT = 11'b11100010010,
  parameter int DOT_LEN   = 10,
  parameter int WORD_BITS = 40,
  parameter int REPEATS   = 5,
  parameter int GRP       = 10,
  parameter int MISS_W    = 4,
  parameter int REP_W     = $clog2(REPEATS),
  parameter int JW        = $clog2(WORD_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              restart,
  input  logic              sel_b,
  input  logic              busy_inv,
  input  logic [MISS_W-1:0] miss_lim,
  output logic              word_vld,
  output logic              word_bit,
  output logic [REP_W-1:0]  word_rep,
  output logic [JW-1:0]     word_pos,
  output logic              busy,
  output logic              busy_evt,
  output logic              in_sync,
  output logic              sync_evt,
  output logic              bitsync_restart
);
  localparam int SYNC_END  = DOT_LEN + SYNC_LEN - 1;
  localparam int DATA_BITS = 2 * REPEATS * WORD_BITS;
  localparam int FRAME_LEN = DOT_LEN + SYNC_LEN + DATA_BITS + DATA_BITS / GRP;
  localparam int POS_W     = $clog2(FRAME_LEN);

  logic             match;
  logic             busy_stb;
  logic [POS_W-1:0] pos;

  fcs_window #(.SYNC_LEN(SYNC_LEN), .SYNC_PAT(SYNC_PAT)) u_window (
    .clk(clk), .rst(rst), .clr(restart), .bit_vld(bit_vld),
    .bit_in(bit_in), .match(match)
  );

  fcs_lock #(.FRAME_LEN(FRAME_LEN), .SYNC_END(SYNC_END), .POS_W(POS_W),
             .MISS_W(MISS_W)) u_lock (
    .clk(clk), .rst(rst), .restart(restart), .bit_vld(bit_vld),
    .match(match), .miss_lim(miss_lim), .pos(pos), .in_sync(in_sync),
    .sync_evt(sync_evt)
  );

  fcs_demux #(.SYNC_END(SYNC_END), .GRP(GRP), .WORD_BITS(WORD_BITS),
              .REPEATS(REPEATS), .POS_W(POS_W), .REP_W(REP_W), .JW(JW)) u_demux (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .in_sync(in_sync), .pos(pos), .sel_b(sel_b), .busy_stb(busy_stb),
    .word_vld(word_vld), .word_bit(word_bit), .word_rep(word_rep),
    .word_pos(word_pos)
  );

  fcs_busy_vote u_vote (
    .clk(clk), .rst(rst), .stb(busy_stb), .bit_in(bit_in),
    .inv(busy_inv), .busy(busy), .busy_evt(busy_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) bitsync_restart <= 1'b0;
    else     bitsync_restart <= restart;
  end

  // R8
  restart_req_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> bitsync_restart);

  // R8
  restart_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !restart |=> !bitsync_restart);
endmodule

// File: tb/fwd_ctl_framer_tb.sv
module fwd_ctl_framer_tb;
  localparam int FLEN = 461;
  localparam logic [10:0] SP = 11'b11100010010;

  typedef struct packed {
    logic       rs;
    logic       good;
    logic       selb;
    logic       inv;
    logic [3:0] lim;
    logic [3:0] pat;
    logic       exp;
  } frame_t;

  localparam int NF = 20;
  localparam frame_t TBL [NF] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'd5, 4'b0000, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'd5, 4'b1011, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd5, 4'b0110, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'd5, 4'b1100, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'd5, 4'b0101, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 4'b1111, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd5, 4'b0000, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'd5, 4'b1110, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 4'b0011, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd5, 4'b1000, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 4'b0111, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd5, 4'b1010, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 4'b1111, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 4'b0001, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 4'b1101, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'b0100, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'b1001, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 4'b0010, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 4'b1110, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 4'b0110, 1'b0}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, bit_vld, bit_in, restart, sel_b, busy_inv;
  logic [3:0] miss_lim;
  logic       word_vld, word_bit, busy, busy_evt, in_sync, sync_evt, bitsync_restart;
  logic [2:0] word_rep;
  logic [5:0] word_pos;

  fwd_ctl_framer u_dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .restart(restart),
    .sel_b(sel_b), .busy_inv(busy_inv), .miss_lim(miss_lim),
    .word_vld(word_vld), .word_bit(word_bit), .word_rep(word_rep),
    .word_pos(word_pos), .busy(busy), .busy_evt(busy_evt), .in_sync(in_sync),
    .sync_evt(sync_evt), .bitsync_restart(bitsync_restart)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit cur_lock = 1'b0;
  bit [2:0] hist = 3'b000;

  task automatic chkv(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic bit wbit(input int f, input int w, input int j);
    return ((f * 7 + w * 5 + j * 3) % 4) < 2;
  endfunction

  function automatic bit vote3(input bit [2:0] h);
    return (int'(h[0]) + int'(h[1]) + int'(h[2])) >= 2;
  endfunction

  initial begin
    rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0; restart = 1'b0;
    sel_b = 1'b0; busy_inv = 1'b0; miss_lim = 4'd5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chkv("R1 reset in_sync", in_sync, 0);
    chkv("R1 reset word_vld", word_vld, 0);
    chkv("R1 reset busy", busy, 0);
    chkv("R1 reset busy_evt", busy_evt, 0);
    chkv("R1 reset sync_evt", sync_evt, 0);
    chkv("R1 reset bitsync_restart", bitsync_restart, 0);

    for (int fi = 0; fi < NF; fi++) begin
      frame_t e;
      e = TBL[fi];
      if (e.rs) begin
        restart = 1'b1;
        bit_vld = 1'b0;
        @(negedge clk);
        restart = 1'b0;
        chkv("R8 restart request", bitsync_restart, 1);
        chkv("R8 lock cleared", in_sync, 0);
        chkv("R6 event on restart", sync_evt, int'(cur_lock));
        cur_lock = 1'b0;
        @(negedge clk);
        chkv("R8 request one cycle", bitsync_restart, 0);
      end
      miss_lim = e.lim;
      sel_b    = e.selb;
      busy_inv = e.inv;
      for (int p = 0; p < FLEN; p++) begin
        bit b;
        int q, g, r, d, w, j;
        q = p - 21; g = 0; r = 0; d = 0; w = 0; j = 0;
        if (p < 10)       b = (p % 2 == 0);
        else if (p < 21)  b = SP[20 - p] ^ ((p == 20) && !e.good);
        else begin
          g = q / 11; r = q % 11;
          if (r == 0) b = e.pat[g % 4];
          else begin
            d = g * 10 + r - 1; w = d / 40; j = d % 40;
            b = wbit(fi, w, j);
          end
        end
        if (p % 7 == 3) begin
          bit_vld = 1'b0;
          @(negedge clk);
          chkv("R10 idle word_vld", word_vld, 0);
          chkv("R10 idle sync_evt", sync_evt, 0);
          chkv("R10 idle lock held", in_sync, int'(cur_lock));
        end
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
        if (p == 20) begin
          chkv("R1 R2 R3 lock at sync end", in_sync, int'(e.exp));
          chkv("R6 sync event", sync_evt, int'(e.exp != cur_lock));
          cur_lock = e.exp;
        end else begin
          chkv("R6 no stray event", sync_evt, 0);
          chkv("R10 lock steady", in_sync, int'(cur_lock));
        end
        if (p < 21) begin
          chkv("R9 header not forwarded", word_vld, 0);
          chkv("R7 no busy event in header", busy_evt, 0);
        end else if (r == 0) begin
          chkv("R4 busy bit not forwarded", word_vld, 0);
          if (cur_lock) begin
            bit old_m, new_m;
            old_m = vote3(hist);
            hist  = {hist[1:0], b};
            new_m = vote3(hist);
            chkv("R5 busy majority", busy, int'(new_m ^ e.inv));
            chkv("R7 busy event", busy_evt, int'(new_m != old_m));
          end else begin
            chkv("R7 no busy event unlocked", busy_evt, 0);
          end
        end else begin
          bit ev;
          ev = cur_lock && ((w % 2) == int'(e.selb));
          chkv(cur_lock ? "R4 word_vld" : "R9 word_vld unlocked", word_vld, int'(ev));
          chkv("R7 no busy event on data", busy_evt, 0);
          if (ev) begin
            chkv("R4 word_bit", word_bit, int'(b));
            chkv("R4 word_rep", word_rep, w / 2);
            chkv("R4 word_pos", word_pos, j);
          end
        end
      end
    end

    busy_inv = ~busy_inv;
    @(negedge clk);
    chkv("R5 polarity flip", busy, int'(vote3(hist) ^ busy_inv));
    busy_inv = ~busy_inv;
    @(negedge clk);
    chkv("R5 polarity restored", busy, int'(vote3(hist) ^ busy_inv));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule